// File: doc/BRIEF.md
# Serial Control Port with Channel Peak Meters

This block is the configuration slave of a stereo converter. A host sends 16-bit command words over a serial link: a serial clock, a data line and an active-low latch line that frames each transfer. A command either writes a 10-bit payload into one of three configuration registers or asks for a register value. The requested word is loaded into the shift path when the latch rises, and it comes out on the data-out line, MSB first, during the next transfer. The configuration registers drive the rest of the chip as plain 10-bit outputs. Inside the first register, the top bit turns the peak meters on. The other fields (gains, rate select, power-down, filter enable) are only stored.

Two peak trackers watch the left and right sample streams. Each one converts the magnitude of every valid sample into an attenuation below full scale, in 1 dB steps from 0 to 63. Between reads it keeps the smallest attenuation it has seen. Reading a peak register returns this value and clears the tracker, so the next sample starts a new measurement.

The shift path is a plain 16-bit register whose MSB drives data-out. Several devices can therefore share one latch line in a daisy chain. The host shifts one word per device through the chain, and every device acts on whichever 16 bits it holds when the shared latch rises.

Top module: `adc_ctrl_port`

## Requirements
- R1: Bits on `sdi` are shifted in MSB first on each rising `sclk` while `latch_n` is low. On the rising edge of `latch_n`, the last 16 bits are decoded as follows: bits 15:12 are the address, bit 11 is the direction (0 = write, 1 = read), bit 10 is ignored, and bits 9:0 are the payload.
- R2: A write to address 0, 1 or 2 stores the payload into `cfg_r1`, `cfg_r2` or `cfg_r3` respectively, and the new value appears a few clocks after the latch edge.
- R3: The configuration registers do not change for a write to any address from 3 to 15, nor for a read command.
- R4: After reset, all three configuration outputs are zero, `sdo` is 0, and both peak registers read as 0.
- R5: On the latch edge of a read command, the word {address, 1, 0, value} is loaded into the shift path. During the next transfer it is driven on `sdo` MSB first, and each bit is valid before the rising `sclk` that shifts it out. Addresses 0–2 return the configuration registers.
- R6: A read of an address from 5 to 15 returns a payload of zero.
- R7: `sdo` carries the bit that entered on `sdi` 16 `sclk` edges earlier. In a transfer longer than 16 bits, only the final 16 bits are acted on.
- R8: Address 3 reads the left peak and address 4 reads the right peak. The attenuation sits in payload bits 5:0, and bits 9:6 read as zero. The attenuation equals the number of steps k = 1..63 for which |x| < (2^(W-1)-1)·10^(-k/20), where W is the sample width. The most negative sample counts as full scale.
- R9: Each tracker reports the smallest attenuation among its own channel's valid samples since its last read.
- R10: A read of a peak register sets that register to 0. The first sample to arrive after the read then loads the register directly, and tracking continues from that value.
- R11: While bit 9 of `cfg_r1` is 0, valid samples are ignored and the peak registers hold their values.
- R12: Toggling `sclk` while `latch_n` is high does not change the shift path or any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial inputs are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial bit clock from the host |
| sdi | input | 1 | Serial command data in |
| latch_n | input | 1 | Active-low transfer frame; rising edge commits |
| sdo | output | 1 | Serial data out (readback or chain pass-through) |
| smp_valid | input | 1 | Strobe marking a valid left/right sample pair |
| smp_left | input | SAMPLE_W | Left sample, two's complement |
| smp_right | input | SAMPLE_W | Right sample, two's complement |
| cfg_r1 | output | 10 | Configuration register at address 0 (bit 9 enables peak metering) |
| cfg_r2 | output | 10 | Configuration register at address 1 |
| cfg_r3 | output | 10 | Configuration register at address 2 |

## Verification
A corrupted shift register shows up on `sdo` during the very next transfer, because every bit of the held word is clocked out. It also reaches the configuration outputs within a few clocks of the next latch edge. A corrupted peak register or fresh flag is only visible when a later read shifts the value out. The bench therefore checks the effect of every sample burst through a full read and readback pair, compared against an attenuation model built from the threshold definition. Configuration state is compared at the ports after every transfer, so a write that leaks to the wrong place appears one transfer later.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  localparam int CMD_W       = 16;
  localparam int ADDR_W      = 4;
  localparam int DATA_W      = 10;
  localparam int PEAK_EN_BIT = 9;

  // Full-scale magnitude scaled down by (step_q16 / 65536) k times, rounded.
  function automatic logic [63:0] att_threshold(input int k, input int mag_w,
                                                input int step_q16);
    logic [63:0] t;
    t = (64'd1 << mag_w) - 64'd1;
    for (int i = 0; i < k; i++) begin
      t = (t * 64'(step_q16) + 64'd32768) >> 16;
    end
    return t;
  endfunction

endpackage

// File: rtl/adc_ctrl_shifter.sv
module adc_ctrl_shifter #(
  parameter int CMD_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              latch_n,
  input  logic              load_en,
  input  logic [CMD_W-1:0]  load_word,
  output logic              sdo,
  output logic              frame_end,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_rd,
  output logic [DATA_W-1:0] cmd_data
);

  logic             sclk_q;
  logic             latch_q;
  logic [CMD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      latch_q <= 1'b1;
      shreg   <= '0;
    end else begin
      sclk_q  <= sclk;
      latch_q <= latch_n;
      if (load_en) begin
        shreg <= load_word;
      end else if (!latch_n && sclk && !sclk_q) begin
        shreg <= {shreg[CMD_W-2:0], sdi};
      end
    end
  end

  assign frame_end = latch_n & ~latch_q;
  assign sdo       = shreg[CMD_W-1];
  assign cmd_addr  = shreg[CMD_W-1 -: ADDR_W];
  assign cmd_rd    = shreg[DATA_W+1];
  assign cmd_data  = shreg[DATA_W-1:0];

endmodule

// File: rtl/adc_peak_tracker.sv
module adc_peak_tracker
  import adc_ctrl_pkg::*;
#(
  parameter int SW       = 24,
  parameter int NSTEP    = 63,
  parameter int STEP_Q16 = 58409,
  parameter int ATT_W    = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 valid,
  input  logic signed [SW-1:0] sample,
  input  logic                 clear,
  output logic [ATT_W-1:0]     peak
);

  localparam int MAG_W = SW - 1;
  localparam logic [MAG_W-1:0] FULL = '1;

  logic [SW-1:0]    neg_s;
  logic [MAG_W-1:0] mag_d, mag_q;
  logic [NSTEP-1:0] below;
  logic [ATT_W-1:0] cnt, att_q;
  logic             v1, v2, fresh;

  always_comb begin
    neg_s = SW'(-sample);
    if (sample[SW-1]) mag_d = neg_s[SW-1] ? FULL : neg_s[MAG_W-1:0];
    else              mag_d = sample[MAG_W-1:0];
  end

  for (genvar k = 1; k <= NSTEP; k++) begin : g_cmp
    localparam logic [MAG_W-1:0] THR = MAG_W'(att_threshold(k, MAG_W, STEP_Q16));
    assign below[k-1] = mag_q < THR;
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NSTEP; i++) cnt = cnt + ATT_W'(below[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q <= '0;
      v1    <= 1'b0;
      att_q <= '0;
      v2    <= 1'b0;
      peak  <= '0;
      fresh <= 1'b1;
    end else begin
      v1    <= valid & en;
      mag_q <= mag_d;
      v2    <= v1;
      att_q <= cnt;
      if (clear) begin
        peak  <= '0;
        fresh <= 1'b1;
      end else if (v2 && en) begin
        if (fresh || att_q < peak) peak <= att_q;
        fresh <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/adc_ctrl_port.sv
module adc_ctrl_port
  import adc_ctrl_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int PEAK_STEPS = 63,
  parameter int STEP_Q16   = 58409
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sclk,
  input  logic                       sdi,
  input  logic                       latch_n,
  output logic                       sdo,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_left,
  input  logic signed [SAMPLE_W-1:0] smp_right,
  output logic [DATA_W-1:0]          cfg_r1,
  output logic [DATA_W-1:0]          cfg_r2,
  output logic [DATA_W-1:0]          cfg_r3
);

  localparam int ATT_W = $clog2(PEAK_STEPS + 1);
  localparam int NREG  = 3;
  localparam int NCH   = 2;

  logic                       frame_end, cmd_rd, load_en;
  logic [ADDR_W-1:0]          cmd_addr;
  logic [DATA_W-1:0]          cmd_data, rd_data;
  logic [CMD_W-1:0]           load_word;
  logic [DATA_W-1:0]          cfg_q [NREG];
  logic [ATT_W-1:0]           peak  [NCH];
  logic [NCH-1:0]             clr;
  logic signed [SAMPLE_W-1:0] smp   [NCH];

  adc_ctrl_shifter #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .latch_n(latch_n),
    .load_en(load_en), .load_word(load_word), .sdo(sdo),
    .frame_end(frame_end), .cmd_addr(cmd_addr), .cmd_rd(cmd_rd), .cmd_data(cmd_data)
  );

  for (genvar j = 0; j < NREG; j++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) cfg_q[j] <= '0;
      else if (frame_end && !cmd_rd && cmd_addr == ADDR_W'(j)) cfg_q[j] <= cmd_data;
    end
  end

  assign cfg_r1 = cfg_q[0];
  assign cfg_r2 = cfg_q[1];
  assign cfg_r3 = cfg_q[2];

  always_comb begin
    rd_data = '0;
    for (int j = 0; j < NREG; j++)
      if (cmd_addr == ADDR_W'(j)) rd_data = cfg_q[j];
    for (int c = 0; c < NCH; c++)
      if (cmd_addr == ADDR_W'(NREG + c)) rd_data = DATA_W'(peak[c]);
  end

  assign load_en   = frame_end & cmd_rd;
  assign load_word = {cmd_addr, 1'b1, 1'b0, rd_data};

  assign smp[0] = smp_left;
  assign smp[1] = smp_right;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign clr[c] = frame_end & cmd_rd & (cmd_addr == ADDR_W'(NREG + c));
    adc_peak_tracker #(.SW(SAMPLE_W), .NSTEP(PEAK_STEPS), .STEP_Q16(STEP_Q16),
                       .ATT_W(ATT_W)) u_trk (
      .clk(clk), .rst(rst), .en(cfg_q[0][PEAK_EN_BIT]), .valid(smp_valid),
      .sample(smp[c]), .clear(clr[c]), .peak(peak[c])
    );
  end

endmodule

// File: rtl/adc_ctrl_port_chk.sv
module adc_ctrl_port_chk #(
  parameter int ATT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             latch_n,
  input logic             sdo,
  input logic [9:0]       cfg_r1,
  input logic [9:0]       cfg_r2,
  input logic [9:0]       cfg_r3,
  input logic             clr_l,
  input logic             clr_r,
  input logic [ATT_W-1:0] peak_l,
  input logic [ATT_W-1:0] peak_r
);

  // R3: configuration only moves on a latch rising edge
  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!latch_n || $past(latch_n)) |=> $stable({cfg_r1, cfg_r2, cfg_r3}));

  // R12: with the latch high, the shift path and data-out are frozen
  p_sdo_idle_r12: assert property (@(posedge clk) disable iff (rst)
    (latch_n && $past(latch_n)) |=> $stable(sdo));

  // R10: a read clears the addressed peak register
  p_clear_l_r10: assert property (@(posedge clk) disable iff (rst)
    clr_l |=> (peak_l == '0));
  p_clear_r_r10: assert property (@(posedge clk) disable iff (rst)
    clr_r |=> (peak_r == '0));

  // R11: with metering disabled, peaks hold
  p_peak_gate_r11: assert property (@(posedge clk) disable iff (rst)
    (!cfg_r1[9] && !clr_l && !clr_r) |=> ($stable(peak_l) && $stable(peak_r)));

  // R5: data-out is always driven to a known level
  p_sdo_known_r5: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(sdo));

endmodule

bind adc_ctrl_port adc_ctrl_port_chk #(.ATT_W(ATT_W)) u_chk (
  .clk(clk), .rst(rst), .latch_n(latch_n), .sdo(sdo),
  .cfg_r1(cfg_r1), .cfg_r2(cfg_r2), .cfg_r3(cfg_r3),
  .clr_l(clr[0]), .clr_r(clr[1]), .peak_l(peak[0]), .peak_r(peak[1])
);

// File: tb/adc_ctrl_port_test.sv
module adc_ctrl_port_test;

  localparam int SW = 24;
  localparam int FS = (1 << (SW - 1)) - 1;
  localparam logic [15:0] NOP = 16'hF000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdi = 1'b0, latch_n = 1'b1;
  logic sdo;
  logic smp_valid = 1'b0;
  logic signed [SW-1:0] smp_left = '0, smp_right = '0;
  logic [9:0] cfg_r1, cfg_r2, cfg_r3;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  int mp [2];
  bit mf [2];
  bit men = 1'b0;

  always #10 clk = ~clk;

  adc_ctrl_port uut (
    .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .latch_n(latch_n), .sdo(sdo),
    .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
    .cfg_r1(cfg_r1), .cfg_r2(cfg_r2), .cfg_r3(cfg_r3)
  );

  // write table: command word and expected {cfg_r1, cfg_r2, cfg_r3} afterwards
  localparam int NV = 9;
  localparam logic [15:0] V_CMD [NV] = '{16'h0155, 16'h12AA, 16'h23FF, 16'h33FF,
                                         16'h4123, 16'hF3FF, 16'h0401, 16'h2000, 16'h0BFF};
  localparam logic [29:0] V_EXP [NV] = '{{10'h155, 10'h000, 10'h000},
                                         {10'h155, 10'h2AA, 10'h000},
                                         {10'h155, 10'h2AA, 10'h3FF},
                                         {10'h155, 10'h2AA, 10'h3FF},
                                         {10'h155, 10'h2AA, 10'h3FF},
                                         {10'h155, 10'h2AA, 10'h3FF},
                                         {10'h001, 10'h2AA, 10'h3FF},
                                         {10'h001, 10'h2AA, 10'h000},
                                         {10'h001, 10'h2AA, 10'h000}};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] w, input int n, output logic [31:0] got);
    got = '0;
    latch_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i]; sclk = 1'b0;
      repeat (4) @(negedge clk);
      got[i] = sdo; sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    latch_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic int exp_att(input longint x);
    real m;
    int cnt;
    m = (x < 0) ? ((x == -longint'(FS) - 1) ? real'(FS) : real'(-x)) : real'(x);
    cnt = 0;
    for (int k = 1; k <= 63; k++)
      if (m < real'(FS) * (10.0 ** (-k / 20.0))) cnt++;
    return cnt;
  endfunction

  task automatic feed(input longint l, input longint r);
    int a [2];
    a[0] = exp_att(l); a[1] = exp_att(r);
    smp_left = SW'(l); smp_right = SW'(r); smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (6) @(negedge clk);
    if (men)
      for (int c = 0; c < 2; c++) begin
        if (mf[c] || a[c] < mp[c]) mp[c] = a[c];
        mf[c] = 1'b0;
      end
  endtask

  task automatic read_peak(input int c, input string tag);
    logic [31:0] g;
    logic [3:0] ad;
    ad = 4'(3 + c);
    xfer({ad, 1'b1, 11'd0}, 16, g);
    xfer(NOP, 16, g);
    check(tag, g[15:0], {ad, 1'b1, 1'b0, 4'b0, 6'(mp[c])});
    mp[c] = 0; mf[c] = 1'b1;
  endtask

  task automatic wr(input logic [15:0] w);
    logic [31:0] g;
    xfer(w, 16, g);
    if (w[15:12] == 4'd0 && !w[11]) men = w[9];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] g;
    for (int c = 0; c < 2; c++) begin mp[c] = 0; mf[c] = 1'b1; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R4 reset state
    check("R4 cfg after reset", {2'b0, cfg_r1, cfg_r2, cfg_r3}, 32'h0);
    check("R4 sdo after reset", sdo, 1'b0);
    read_peak(1, "R4 right peak after reset");

    // R1 R2 R3 table walk
    for (int v = 0; v < NV; v++) begin
      xfer(V_CMD[v], 16, g);
      check($sformatf("R1 R2 R3 vector %0d", v), {cfg_r1, cfg_r2, cfg_r3}, V_EXP[v]);
    end

    // R8 R9 peak tracking
    wr(16'h0200);
    feed(FS / 3, FS / 128);
    feed(FS / 128, FS / 2);
    read_peak(0, "R9 left min of 9/42 dB");
    read_peak(1, "R9 right min of 42/6 dB");
    read_peak(0, "R10 left after clear no samples");
    feed(FS / 128, 0);
    read_peak(0, "R10 left restart loads 42");
    read_peak(1, "R8 right zero sample is 63");
    feed(-longint'(FS) - 1, -(FS / 3));
    read_peak(0, "R8 most negative is full scale");
    read_peak(1, "R8 negative magnitude");
    feed(FS / 2000, FS / 4);
    read_peak(0, "R8 below floor clamps 63");
    read_peak(1, "R8 quarter scale");

    // R11 enable off holds
    feed(FS / 128, FS / 128);
    wr(16'h0000);
    feed(FS, FS);
    read_peak(0, "R11 disabled left holds");
    read_peak(1, "R11 disabled right holds");

    // R5 readback of a configuration register
    wr(16'h1155);
    xfer(16'h1800, 16, g);
    check("R3 read leaves cfg_r2", cfg_r2, 10'h155);
    xfer(NOP, 16, g);
    check("R5 readback addr1", g[15:0], 16'h1955);

    // R6 unmapped read
    xfer(16'h9BFF, 16, g);
    xfer(NOP, 16, g);
    check("R6 unmapped read", g[15:0], 16'h9800);

    // R12 sclk while latch high
    xfer(16'h1800, 16, g);
    sdi = 1'b1;
    for (int i = 0; i < 20; i++) begin
      sclk = 1'b1; repeat (3) @(negedge clk);
      sclk = 1'b0; repeat (3) @(negedge clk);
    end
    check("R12 cfg untouched", {cfg_r1, cfg_r2, cfg_r3}, {10'h000, 10'h155, 10'h000});
    xfer(NOP, 16, g);
    check("R12 shift path untouched", g[15:0], 16'h1955);

    // R7 chain pass-through: shift path now holds NOP
    xfer({16'h2155, 16'h1000}, 32, g);
    check("R7 first half shows held word", g[31:16], NOP);
    check("R7 second half shows first word", g[15:0], 16'h2155);
    check("R7 only last word commits", {cfg_r2, cfg_r3}, {10'h000, 10'h000});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule